// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory uses for each access. A load cycle captures a full external address and opens a burst. Each later advance cycle moves the burst to its next beat. Only the lowest address bits change during a burst; the upper part stays as it was loaded. The low bits follow one of two orders, chosen by a static order input. In linear order they count upward and wrap modulo the burst length. In interleaved order they are the start offset XORed with the beat number.

A clock-enable input freezes the whole block when it is low. A deselect input closes the current burst, so the next access has to come from a fresh load. An advance request made while no burst is open is ignored. The outputs are the current address, the beat number, a flag that marks the final beat, and a flag that shows a burst is open. All outputs come straight from registers.

Top module: `burst_addr_ctr`

## Requirements
- R1: After reset, `addr` is 0, `beat` is 0, and both `active` and `last` are low.
- R2: A cycle with `en`=1, `desel`=0 and `adv`=0 is a load. After that edge, `addr` equals `ext_addr`, `beat` is 0 and `active` is 1.
- R3: Linear order (`order_ilv`=0). On beat n the low two bits of `addr` are (start + n) mod 4, where start is the low two bits that were loaded. The upper bits keep their loaded value.
- R4: Interleaved order (`order_ilv`=1). On beat n the low two bits of `addr` are start XOR n, and the upper bits keep their loaded value.
- R5: An advance (`en`=1, `desel`=0, `adv`=1, `active`=1) raises `beat` by one modulo 4. An advance from beat 3 returns `beat` to 0 and the low address bits to the start offset.
- R6: While `en`=0, `addr`, `beat`, `active` and `last` keep their values, whatever the other inputs do.
- R7: A cycle with `en`=1 and `desel`=1 clears `active`, `last` and `beat` and leaves `addr` unchanged. Deselect takes priority over a load in the same cycle.
- R8: An advance while `active`=0 changes nothing: `addr` and `beat` hold and `active` stays low until a load.
- R9: `last` is 1 exactly when `active` is 1 and `beat` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Clock enable, high to let the block update |
| adv | input | 1 | 1 = advance the burst, 0 = load `ext_addr` |
| desel | input | 1 | Deselect, closes the burst |
| order_ilv | input | 1 | Burst order strap: 1 interleaved, 0 linear; hold static |
| ext_addr | input | ADDR_W | External address taken on a load |
| addr | output | ADDR_W | Current access address |
| beat | output | BURST_BITS | Beat number within the burst |
| last | output | 1 | High on the final beat of an open burst |
| active | output | 1 | High while a burst is open |

## Verification
Every start offset from 0 to 3 is run in both orders over eight advances, which goes past the wrap. This shows whether the step is an addition or an XOR, and whether the wrap returns to the start offset rather than to zero. The same bursts are repeated with stall cycles between beats, during which load-like inputs and new addresses are applied. A change at such a point exposes any leak through the enable. A deselect sequence with a competing load, followed by a stray advance and then a reload, separates the deselect priority from the ignored-advance case.

// File: rtl/burst_pkg.sv
package burst_pkg;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

endpackage

// File: rtl/burst_beat_next.sv
module burst_beat_next #(
    parameter int BURST_BITS = 2
) (
    input  logic [BURST_BITS-1:0] beat_cur,
    output logic [BURST_BITS-1:0] beat_inc,
    output logic                  beat_inc_last
);
    localparam int BURST_LEN = 1 << BURST_BITS;
    localparam logic [BURST_BITS-1:0] LAST_BEAT = BURST_BITS'(BURST_LEN - 1);

    always_comb begin
        beat_inc      = beat_cur + BURST_BITS'(1);
        beat_inc_last = (beat_inc == LAST_BEAT);
    end
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
    import burst_pkg::*;
#(
    parameter int BURST_BITS = 2
) (
    input  burst_order_e          order,
    input  logic [BURST_BITS-1:0] start_off,
    input  logic [BURST_BITS-1:0] beat_num,
    output logic [BURST_BITS-1:0] low_bits
);
    logic [BURST_BITS-1:0] lin_bits;
    logic [BURST_BITS-1:0] ilv_bits;

    genvar gi;
    generate
        for (gi = 0; gi < BURST_BITS; gi++) begin : g_xor
            assign ilv_bits[gi] = start_off[gi] ^ beat_num[gi];
        end
    endgenerate

    always_comb begin
        lin_bits = start_off + beat_num;
        low_bits = (order == ORD_INTERLEAVE) ? ilv_bits : lin_bits;
    end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
    import burst_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  adv,
    input  logic                  desel,
    input  logic                  order_ilv,
    input  logic [ADDR_W-1:0]     ext_addr,
    output logic [ADDR_W-1:0]     addr,
    output logic [BURST_BITS-1:0] beat,
    output logic                  last,
    output logic                  active
);
    localparam int UP_W = ADDR_W - BURST_BITS;

    typedef struct packed {
        logic [UP_W-1:0]       upper;
        logic [BURST_BITS-1:0] start;
        logic [BURST_BITS-1:0] low;
        logic [BURST_BITS-1:0] beat;
        logic                  active;
        logic                  last;
    } ctr_state_t;

    ctr_state_t st_d, st_q;

    logic [BURST_BITS-1:0] beat_inc;
    logic                  beat_inc_last;
    logic [BURST_BITS-1:0] low_inc;
    burst_order_e          order;

    assign order = burst_order_e'(order_ilv);

    burst_beat_next #(.BURST_BITS(BURST_BITS)) u_beat (
        .beat_cur      (st_q.beat),
        .beat_inc      (beat_inc),
        .beat_inc_last (beat_inc_last)
    );

    burst_offset_map #(.BURST_BITS(BURST_BITS)) u_map (
        .order     (order),
        .start_off (st_q.start),
        .beat_num  (beat_inc),
        .low_bits  (low_inc)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            if (desel) begin
                st_d.active = 1'b0;
                st_d.last   = 1'b0;
                st_d.beat   = '0;
            end else if (!adv) begin
                st_d.upper  = ext_addr[ADDR_W-1:BURST_BITS];
                st_d.start  = ext_addr[BURST_BITS-1:0];
                st_d.low    = ext_addr[BURST_BITS-1:0];
                st_d.beat   = '0;
                st_d.active = 1'b1;
                st_d.last   = 1'b0;
            end else if (st_q.active) begin
                st_d.beat = beat_inc;
                st_d.low  = low_inc;
                st_d.last = beat_inc_last;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr   = {st_q.upper, st_q.low};
    assign beat   = st_q.beat;
    assign last   = st_q.last;
    assign active = st_q.active;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en,
    input logic                  adv,
    input logic                  desel,
    input logic                  order_ilv,
    input logic [ADDR_W-1:0]     ext_addr,
    input logic [ADDR_W-1:0]     addr,
    input logic [BURST_BITS-1:0] beat,
    input logic                  last,
    input logic                  active
);
    logic step_c;
    assign step_c = en && !desel && adv && active;

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !desel && !adv) |=> (addr == $past(ext_addr) && beat == '0 && active)); // R2

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_c && !order_ilv) |=> (addr[BURST_BITS-1:0] == BURST_BITS'($past(addr[BURST_BITS-1:0]) + 1'b1))); // R3

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        step_c |=> $stable(addr[ADDR_W-1:BURST_BITS])); // R4

    AST_BEAT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        step_c |=> (beat == BURST_BITS'($past(beat) + 1'b1))); // R5

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ($stable(addr) && $stable(beat) && $stable(active) && $stable(last))); // R6

    AST_DESEL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && desel) |=> (!active && !last && $stable(addr))); // R7

    AST_IDLE_ADV_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !desel && adv && !active) |=> ($stable(addr) && $stable(beat) && !active)); // R8

    AST_LAST_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> active); // R9
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .adv       (adv),
    .desel     (desel),
    .order_ilv (order_ilv),
    .ext_addr  (ext_addr),
    .addr      (addr),
    .beat      (beat),
    .last      (last),
    .active    (active)
);

// File: tb/burst_addr_ctr_test.sv
module burst_addr_ctr_test;
    localparam int AW = 17;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          adv = 1'b0;
    logic          desel = 1'b0;
    logic          order_ilv = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] addr;
    logic [BB-1:0] beat;
    logic          last;
    logic          active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_ctr #(.ADDR_W(AW), .BURST_BITS(BB)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .adv(adv), .desel(desel),
        .order_ilv(order_ilv), .ext_addr(ext_addr),
        .addr(addr), .beat(beat), .last(last), .active(active)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] ref_low(input logic [1:0] s, input int n, input bit ilv);
        logic [1:0] nn;
        nn = 2'(n);
        return ilv ? (s ^ nn) : 2'(s + nn);
    endfunction

    // Drive inputs at negedge, let one rising edge pass, sample 1 ns after it.
    task automatic cyc(input bit e, input bit a, input bit d, input logic [AW-1:0] ea);
        @(negedge clk);
        en = e; adv = a; desel = d; ext_addr = ea;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk("R1 addr", 32'(addr), 0);
        chk("R1 beat", 32'(beat), 0);
        chk("R1 active", 32'(active), 0);
        chk("R1 last", 32'(last), 0);
    endtask

    task automatic t_burst(input bit ilv, input logic [1:0] s, input logic [AW-3:0] up, input bit stalls);
        logic [AW-1:0] held;
        string rq;
        rq = ilv ? "R4" : "R3";
        @(negedge clk);
        order_ilv = ilv;
        cyc(1, 0, 0, {up, s});
        chk("R2 load addr", 32'(addr), 32'({up, s}));
        chk("R2 load beat", 32'(beat), 0);
        chk("R2 load active", 32'(active), 1);
        for (int k = 1; k <= 8; k++) begin
            if (stalls) begin
                held = addr;
                cyc(0, 0, 1, ~held);
                chk("R6 stall addr", 32'(addr), 32'(held));
                chk("R6 stall beat", 32'(beat), 32'((k - 1) % 4));
                chk("R6 stall active", 32'(active), 1);
            end
            cyc(1, 1, 0, ~{up, s});
            chk({rq, " addr"}, 32'(addr), 32'({up, ref_low(s, k, ilv)}));
            chk("R5 beat", 32'(beat), 32'(k % 4));
            chk("R9 last", 32'(last), 32'((k % 4) == 3));
        end
        chk("R5 wrap to start", 32'(addr[1:0]), 32'(s));
    endtask

    task automatic t_desel();
        logic [AW-1:0] a0;
        a0 = 17'h1ABC6;
        order_ilv = 1'b0;
        cyc(1, 0, 0, a0);
        cyc(1, 1, 0, '0);
        cyc(1, 1, 0, '0);
        cyc(1, 1, 0, '0);
        chk("R9 last at beat3", 32'(last), 1);
        cyc(1, 0, 1, 17'h00F0F);
        chk("R7 active cleared", 32'(active), 0);
        chk("R7 last cleared", 32'(last), 0);
        chk("R7 beat cleared", 32'(beat), 0);
        chk("R7 addr held over load", 32'(addr), 32'({a0[AW-1:2], 2'b01}));
        cyc(1, 1, 0, 17'h00F0F);
        chk("R8 adv idle addr", 32'(addr), 32'({a0[AW-1:2], 2'b01}));
        chk("R8 adv idle beat", 32'(beat), 0);
        chk("R8 adv idle active", 32'(active), 0);
        cyc(0, 0, 0, 17'h00F0F);
        chk("R6 no load when frozen", 32'(active), 0);
        cyc(1, 0, 0, 17'h00F0F);
        chk("R2 reload addr", 32'(addr), 32'h00F0F);
        chk("R2 reload active", 32'(active), 1);
    endtask

    initial begin
        #3;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 0, 17'h1FFFF);
        chk("R8 adv after reset", 32'(addr), 0);
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                t_burst(m[0], 2'(s), 15'(15'h1234 + s * 77 + m), 1'b0);
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                t_burst(m[0], 2'(s), 15'(15'h7A00 - s * 31 - m), 1'b1);
        t_desel();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule